// File: doc/BRIEF.md
# Byte-Wide Erasable One-Time-Clear Memory Model

This block is a synthesizable stand-in for a byte-wide read-only memory that can be erased by ultraviolet light and programmed electrically. The array depth is set by a parameter. Each byte starts as all ones. A program operation can only clear bits from 1 to 0. A single synchronous erase command sets every cell back to ones. The analog parts of the real device are left out: supply levels, access delays and the exposure time for erase.

Two flags stand in for the elevated voltages. `prog_supply` stands for the raised programming supply. `id_mode` stands for the raised level on the address line that selects the identification codes. The active-low enables `ce_n` and `oe_n`, together with these two flags, select one of seven modes:

- read
- output disable
- standby
- program
- program verify
- program inhibit
- signature read

The data bus is modelled as a separate input, a separate output and a drive-enable. `rd_data` is held at zero whenever `rd_drive` is low. Outputs are combinational from the inputs and the stored array. Stores take effect at the rising clock edge.

Top module: `uvprom_model`

## Requirements
- R1: After reset, and in the cycle after any cycle with `erase` high, every address reads 8'hFF. `erase` takes effect at the clock edge.
- R2: With `ce_n`=0, `oe_n`=0, `prog_supply`=0 and `id_mode`=0, `rd_drive` is 1 and `rd_data` is the byte stored at `addr`.
- R3: With `ce_n`=0 and `oe_n`=1, `rd_drive` is 0 and `rd_data` is 8'h00, whatever the state of `prog_supply`.
- R4: With `ce_n`=1, `rd_drive` is 0 and `rd_data` is 8'h00 for any value of `oe_n`, `prog_supply` and `id_mode`.
- R5: A clock edge with `prog_supply`=1, `ce_n`=0, `oe_n`=1 and `erase`=0 stores `old & wr_data` at `addr`. A 1 in `wr_data` leaves that bit unchanged, and no bit ever rises except by erase.
- R6: No byte changes at a clock edge unless all program conditions hold. This covers the case where `prog_supply` is 0 (output disable), the case where `ce_n` is 1 (inhibit), and the case where `oe_n` is 0 (verify).
- R7: With `prog_supply`=1, `ce_n`=0 and `oe_n`=0 (verify), the stored byte is driven. `id_mode` is ignored in this mode.
- R8: With `prog_supply`=0, `ce_n`=0, `oe_n`=0 and `id_mode`=1, the block drives `MFR_CODE` when `addr[0]`=0 and `DEV_CODE` when `addr[0]`=1, in place of array data.
- R9: When `erase` and the program conditions occur in the same cycle, the erase wins, so the addressed byte reads 8'hFF afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for stores and erase |
| rst_n | input | 1 | Active-low reset; sets the array to ones |
| addr | input | ADDR_W | Byte address |
| wr_data | input | 8 | Data presented for programming |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| prog_supply | input | 1 | Programming supply raised |
| id_mode | input | 1 | Identification level on the address line |
| erase | input | 1 | Synchronous erase to all ones |
| rd_data | output | 8 | Data driven onto the bus |
| rd_drive | output | 1 | Bus drive enable |

## Verification
A corrupted cell shows up at the ports on the first read or verify of that address. This happens the same cycle, because the output path has no register. A wrong mode decode shows up at once on `rd_drive` or `rd_data`. A program that sets a bit, or a store in a mode that should not write, shows up on the following read of that byte. The bench therefore reads back every touched address directly after each write attempt.

// File: rtl/uvprom_model.sv
module uvprom_model #(
  parameter int          ADDR_W   = 10,
  parameter logic [7:0]  MFR_CODE = 8'h3C,
  parameter logic [7:0]  DEV_CODE = 8'h9A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              prog_supply,
  input  logic              id_mode,
  input  logic              erase,
  output logic [7:0]        rd_data,
  output logic              rd_drive
);

  localparam int DEPTH = 1 << ADDR_W;

  typedef enum logic [2:0] {
    M_STANDBY, M_DISABLE, M_READ, M_SIGN, M_PROGRAM, M_VERIFY, M_INHIBIT
  } mode_t;

  logic [7:0] cells [DEPTH];
  mode_t      mode;
  logic       do_prog;
  logic [7:0] cur_byte;

  always_comb begin
    if (prog_supply) begin
      if (ce_n)       mode = M_INHIBIT;
      else if (oe_n)  mode = M_PROGRAM;
      else            mode = M_VERIFY;
    end else begin
      if (ce_n)         mode = M_STANDBY;
      else if (oe_n)    mode = M_DISABLE;
      else if (id_mode) mode = M_SIGN;
      else              mode = M_READ;
    end
  end

  assign cur_byte = cells[addr];
  assign do_prog  = (mode == M_PROGRAM) && !erase;
  assign rd_drive = (mode == M_READ) || (mode == M_SIGN) || (mode == M_VERIFY);

  always_comb begin
    case (mode)
      M_READ, M_VERIFY: rd_data = cur_byte;
      M_SIGN:           rd_data = addr[0] ? DEV_CODE : MFR_CODE;
      default:          rd_data = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
    end else if (erase) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
    end else if (do_prog) begin
      cells[addr] <= cur_byte & wr_data;
    end
  end

  assert_erase_ones_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(erase)) |-> (cur_byte == 8'hFF));

  assert_only_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(erase)) |->
      ((cells[$past(addr)] & ~$past(cur_byte)) == 8'h00));

  assert_and_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(erase) && $past(prog_supply) && !$past(ce_n) && $past(oe_n)) |->
      (cells[$past(addr)] == ($past(cur_byte) & $past(wr_data))));

  assert_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(erase) && !($past(prog_supply) && !$past(ce_n) && $past(oe_n))) |->
      (cells[$past(addr)] == $past(cur_byte)));

  assert_standby_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> (!rd_drive && rd_data == 8'h00));

endmodule

// File: tb/tb_uvprom_model.sv
module tb_uvprom_model;
  localparam int         AW  = 10;
  localparam logic [7:0] MFR = 8'h3C;
  localparam logic [7:0] DEV = 8'h9A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wr_data = 8'h00;
  logic ce_n = 1'b1, oe_n = 1'b1, prog_supply = 1'b0, id_mode = 1'b0, erase = 1'b0;
  logic [7:0] rd_data;
  logic rd_drive;

  always #2.5 clk = ~clk;

  uvprom_model #(.ADDR_W(AW), .MFR_CODE(MFR), .DEV_CODE(DEV)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data), .ce_n(ce_n),
    .oe_n(oe_n), .prog_supply(prog_supply), .id_mode(id_mode), .erase(erase),
    .rd_data(rd_data), .rd_drive(rd_drive)
  );

  typedef struct {
    string      tag;
    logic       drv;
    logic [7:0] dat;
  } item_t;

  item_t      q[$];
  logic [7:0] ref_mem [1 << AW];
  int compared = 0, mismatched = 0;
  bit finished = 0;

  initial begin
    forever begin
      wait (q.size() > 0);
      begin
        item_t it;
        it = q.pop_front();
        compared++;
        if (rd_drive !== it.drv || rd_data !== it.dat) begin
          mismatched++;
          $display("FAIL %s: got drive=%b data=%h, expected drive=%b data=%h",
                   it.tag, rd_drive, rd_data, it.drv, it.dat);
        end
      end
    end
  end

  task automatic step(input logic c, input logic o, input logic v, input logic s,
                      input logic e, input int a, input logic [7:0] d,
                      input bit chk, input string tag);
    item_t it;
    logic [AW-1:0] aa;
    aa = AW'(a);
    @(negedge clk);
    ce_n = c; oe_n = o; prog_supply = v; id_mode = s; erase = e;
    addr = aa; wr_data = d;
    it.tag = tag;
    it.drv = !c && !o;
    if (!it.drv)        it.dat = 8'h00;
    else if (!v && s)   it.dat = aa[0] ? DEV : MFR;
    else                it.dat = ref_mem[aa];
    #1;
    if (chk) q.push_back(it);
    if (e) begin
      for (int i = 0; i < (1 << AW); i++) ref_mem[i] = 8'hFF;
    end else if (v && !c && o) begin
      ref_mem[aa] = ref_mem[aa] & d;
    end
  endtask

  task automatic rd(input int a, input string tag);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, a, 8'h00, 1'b1, tag);
  endtask

  task automatic prog(input int a, input logic [7:0] d);
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, a, d, 1'b0, "prog");
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) ref_mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(0, "R1 fresh addr0");
    rd(5, "R1 fresh addr5");
    rd((1 << AW) - 1, "R1 fresh top");

    step(1, 0, 0, 0, 0, 7, 8'h00, 1, "R4 standby oe low");
    step(1, 1, 1, 1, 0, 7, 8'h00, 1, "R4 standby all raised");
    step(0, 1, 0, 0, 0, 7, 8'h00, 1, "R3 output disable");
    step(0, 1, 1, 0, 0, 7, 8'h55, 1, "R3 disable during program");
    rd(7, "R5 program applied");

    prog(3, 8'hA5);
    rd(3, "R5 first program");
    prog(3, 8'h0F);
    rd(3, "R5 and of second program");
    prog(3, 8'hFF);
    rd(3, "R5 ones leave bits");
    rd(2, "R5 neighbour untouched");

    step(0, 1, 0, 0, 0, 9, 8'h00, 0, "disable write");
    rd(9, "R6 no write without supply");
    step(1, 1, 1, 0, 0, 9, 8'h00, 0, "inhibit");
    rd(9, "R6 no write while inhibited");
    step(0, 0, 1, 0, 0, 9, 8'h00, 0, "verify");
    rd(9, "R6 no write during verify");

    step(0, 0, 1, 1, 0, 3, 8'h00, 1, "R7 verify ignores id");
    step(0, 0, 1, 0, 0, 7, 8'h00, 1, "R7 verify addr7");

    step(0, 0, 0, 1, 0, 4, 8'h00, 1, "R8 manufacturer code");
    step(0, 0, 0, 1, 0, 3, 8'h00, 1, "R8 device code");
    rd(3, "R2 array back after id");

    for (int k = 0; k < 16; k++) begin
      prog(100 + k, 8'((k * 37) ^ 8'hC3));
      rd(100 + k, "R2 pattern readback");
    end

    step(0, 1, 0, 0, 1, 0, 8'h00, 0, "erase");
    rd(3, "R1 after erase addr3");
    rd(105, "R1 after erase addr105");

    prog(20, 8'h11);
    step(0, 1, 1, 0, 1, 20, 8'h00, 0, "erase plus program");
    rd(20, "R9 erase wins");

    #20;
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule